// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core Model

This block is a synthesizable device-side model of a double-data-rate static memory that moves data in bursts of four words. It runs from one clock at twice the command rate. Every even cycle is a K tick and every odd cycle is a K# tick, and the block drives `k_tick` so a controller can see which is which. Commands are taken only on K ticks. A write collects its four words on the four half-cycles that follow the next K tick. A read drives its four words on consecutive half-cycles, starting a fixed number of cycles after the command.

Each storage entry holds four words side by side. The two low address bits select the first word of the burst. The burst then walks upward through the entry and wraps back to word 0 without touching the entry index. Each write word has its own byte-enable mask. Read data is qualified by `rdata_oe`, which stands in for the tri-state enable of a real data bus. The block serves as the memory-side counterpart when checking a controller.

Top module: `ddrb4_sram`

## Requirements
- R1: After reset, `rdata_oe` is 0 and `rdata` is zero. `k_tick` is 1 in the first cycle after reset and then alternates every cycle, so it is 1 in every even cycle counted from reset release.
- R2: A command is taken only in a cycle with `k_tick`=1 and `ld_n`=0. With `ld_n`=1 nothing is read or written.
- R3: A command presented in a cycle with `k_tick`=0 is ignored.
- R4: After an accepted command, a command at the very next K tick (two cycles later) is ignored. Commands four or more cycles apart are each accepted.
- R5: `rw`=0 selects a write and `rw`=1 selects a read. `addr[ADDR_W-1:2]` is the entry and `addr[1:0]` is the start word s. For a write taken in cycle t, burst word j (j=0..3) is presented on `wdata`/`wbe` in cycle t+2+j. It lands in word (s+j) mod 4 of the entry, so word 0 arrives on a K tick.
- R6: `wbe[b]`=1 writes byte b of the presented word, where byte b is bits [8b+7:8b]. `wbe[b]`=0 leaves that byte of the stored word unchanged.
- R7: For a read taken in cycle t, burst word j appears on `rdata` in cycle t+RD_LAT+j. Its value is stored word (s+j) mod 4 of the same entry, so a burst wraps inside the entry and the entry index never increments. RD_LAT may be 3 or 4.
- R8: `rdata_oe` is 1 exactly in cycles that carry read burst words. In every other cycle it is 0 and `rdata` is zero.
- R9: A read taken four cycles after a write to the same entry returns the newly written data. A read taken four cycles before a write returns the data that was stored before that write.
- R10: Reset clears every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each cycle is one half of a K period |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Command load, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ENTRY_AW+2 | Entry index above, start word in bits [1:0] |
| wdata | input | WORD_W | Write burst word |
| wbe | input | WORD_W/BYTE_W | Byte-write enables for the current write word |
| k_tick | output | 1 | High in K-tick cycles |
| rdata | output | WORD_W | Read burst word, zero when not enabled |
| rdata_oe | output | 1 | Output-enable flag for `rdata` |

## Verification
Relative to a command taken in cycle t, write word j is sampled in cycle t+2+j and read word j is due on the outputs in cycle t+RD_LAT+j. `k_tick` is due in every cycle, set by the parity of the cycle count. The bench plans the whole run ahead of time. Each planned read takes a snapshot of the reference memory as it stands after all earlier accepted writes. That snapshot fills per-cycle tables of the expected `rdata_oe`, `rdata` and `k_tick`. Each cycle, the outputs are compared against the table entry at mid-period, after the edge that set them. As a result, ignored commands, wrap order, byte masks and the write/read hazards all show up at their exact cycle.

// File: rtl/ddrb4_pkg.sv
// Package: shared helpers for the burst-of-four SRAM model.
// Assumes bursts are always four words long; word positions are 2 bits.
package ddrb4_pkg;

    localparam int unsigned BURST_LEN = 4;

    // Position inside the entry of burst word `ord` for a burst starting at `start`.
    function automatic logic [1:0] burst_pos(input logic [1:0] start, input logic [1:0] ord);
        return start + ord;
    endfunction

endpackage

// File: rtl/ddrb4_cmd_decode.sv
// Command decode: tracks K / K# phase and accepts commands on K ticks.
// Assumes the first cycle after reset is a K tick. A command taken on one
// K tick blocks the next K tick, because a burst spans two K periods.
module ddrb4_cmd_decode #(
    parameter int unsigned ENTRY_AW = 4,
    localparam int unsigned ADDR_W  = ENTRY_AW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_n,
    input  logic                rw,
    input  logic [ADDR_W-1:0]   addr,
    output logic                k_tick,
    output logic                acc_rd,
    output logic                acc_wr,
    output logic [ENTRY_AW-1:0] acc_entry,
    output logic [1:0]          acc_start
);
    logic phase;
    logic hold;
    logic take;

    // Phase toggle: 0 marks a K tick.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Block the K tick right after an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold <= 1'b0;
        else if (k_tick) hold <= take;
    end

    // Acceptance and field split.
    always_comb begin
        k_tick    = ~phase;
        take      = rst_n & k_tick & ~ld_n & ~hold;
        acc_rd    = take & rw;
        acc_wr    = take & ~rw;
        acc_entry = addr[ADDR_W-1:2];
        acc_start = addr[1:0];
    end
endmodule

// File: rtl/ddrb4_wr_seq.sv
// Write sequencer: holds an accepted write until the next K tick, then
// steers four incoming words into their wrapped positions, one per cycle.
// Assumes commands are at least two K periods apart (enforced upstream).
module ddrb4_wr_seq #(
    parameter int unsigned ENTRY_AW = 4,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    localparam int unsigned NBYTE   = WORD_W / BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                k_tick,
    input  logic                acc_wr,
    input  logic [ENTRY_AW-1:0] acc_entry,
    input  logic [1:0]          acc_start,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [NBYTE-1:0]    wbe,
    output logic                mem_we,
    output logic [ENTRY_AW-1:0] mem_entry,
    output logic [1:0]          mem_pos,
    output logic [WORD_W-1:0]   mem_data,
    output logic [NBYTE-1:0]    mem_be,
    output logic [1:0]          wr_ord
);
    import ddrb4_pkg::*;

    logic                nxt_v;
    logic [ENTRY_AW-1:0] nxt_e;
    logic [1:0]          nxt_s;
    logic                act;
    logic [ENTRY_AW-1:0] cur_e;
    logic [1:0]          cur_s;
    logic [1:0]          cnt;
    logic                promote;

    // Park the accepted write until its first data K tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_v <= 1'b0;
            nxt_e <= '0;
            nxt_s <= '0;
        end else if (acc_wr) begin
            nxt_v <= 1'b1;
            nxt_e <= acc_entry;
            nxt_s <= acc_start;
        end else if (promote) begin
            nxt_v <= 1'b0;
        end
    end

    // Track words 1..3 after word 0 has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            cur_e <= '0;
            cur_s <= '0;
            cnt   <= '0;
        end else if (promote) begin
            act   <= 1'b1;
            cur_e <= nxt_e;
            cur_s <= nxt_s;
            cnt   <= 2'd1;
        end else if (act) begin
            cnt <= cnt + 2'd1;
            act <= (cnt != 2'd3);
        end
    end

    // Storage write port steering.
    always_comb begin
        promote   = nxt_v & k_tick;
        mem_we    = promote | act;
        mem_entry = promote ? nxt_e : cur_e;
        wr_ord    = promote ? 2'd0 : cnt;
        mem_pos   = burst_pos(promote ? nxt_s : cur_s, wr_ord);
        mem_data  = wdata;
        mem_be    = mem_we ? wbe : '0;
    end
endmodule

// File: rtl/ddrb4_store.sv
// Storage array: DEPTH entries of four words, split into byte lanes so
// each lane has a single writer. Cleared on reset; read is combinational.
module ddrb4_store #(
    parameter int unsigned ENTRY_AW = 4,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    localparam int unsigned NBYTE   = WORD_W / BYTE_W,
    localparam int unsigned DEPTH   = 1 << ENTRY_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ENTRY_AW-1:0] w_entry,
    input  logic [1:0]          w_pos,
    input  logic [WORD_W-1:0]   w_data,
    input  logic [NBYTE-1:0]    w_be,
    input  logic [ENTRY_AW-1:0] r_entry,
    input  logic [1:0]          r_pos,
    output logic [WORD_W-1:0]   r_word
);
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH][4];

        // Byte-lane write with per-byte enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < DEPTH; e++)
                    for (int p = 0; p < 4; p++)
                        lane_mem[e][p] <= '0;
            end else if (we && w_be[b]) begin
                lane_mem[w_entry][w_pos] <= w_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign r_word[b*BYTE_W +: BYTE_W] = lane_mem[r_entry][r_pos];
    end
endmodule

// File: rtl/ddrb4_rd_seq.sv
// Read sequencer: delays accepted reads by RD_LAT-1 cycles, then fetches
// four wrapped words on consecutive cycles into the output register.
// Assumes RD_LAT is 3 or 4 and reads are at least four cycles apart.
module ddrb4_rd_seq #(
    parameter int unsigned ENTRY_AW = 4,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned RD_LAT   = 4,
    localparam int unsigned NSTAGE  = RD_LAT - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_rd,
    input  logic [ENTRY_AW-1:0] acc_entry,
    input  logic [1:0]          acc_start,
    output logic [ENTRY_AW-1:0] f_entry,
    output logic [1:0]          f_pos,
    input  logic [WORD_W-1:0]   f_word,
    output logic [WORD_W-1:0]   rdata,
    output logic                rdata_oe
);
    import ddrb4_pkg::*;

    logic [NSTAGE-1:0]   pv;
    logic [ENTRY_AW-1:0] pe [NSTAGE];
    logic [1:0]          ps [NSTAGE];
    logic                act;
    logic [ENTRY_AW-1:0] cur_e;
    logic [1:0]          cur_s;
    logic [1:0]          cnt;
    logic                launch;
    logic                load;

    // Latency pipe for read descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
            for (int i = 0; i < NSTAGE; i++) begin
                pe[i] <= '0;
                ps[i] <= '0;
            end
        end else begin
            pv[0] <= acc_rd;
            pe[0] <= acc_entry;
            ps[0] <= acc_start;
            for (int i = 1; i < NSTAGE; i++) begin
                pv[i] <= pv[i-1];
                pe[i] <= pe[i-1];
                ps[i] <= ps[i-1];
            end
        end
    end

    // Burst engine for words 1..3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            cur_e <= '0;
            cur_s <= '0;
            cnt   <= '0;
        end else if (launch) begin
            act   <= 1'b1;
            cur_e <= pe[NSTAGE-1];
            cur_s <= ps[NSTAGE-1];
            cnt   <= 2'd1;
        end else if (act) begin
            cnt <= cnt + 2'd1;
            act <= (cnt != 2'd3);
        end
    end

    // Fetch address selection.
    always_comb begin
        launch  = pv[NSTAGE-1];
        load    = launch | act;
        f_entry = launch ? pe[NSTAGE-1] : cur_e;
        f_pos   = launch ? ps[NSTAGE-1] : burst_pos(cur_s, cnt);
    end

    // Output register and enable; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata    <= load ? f_word : '0;
            rdata_oe <= load;
        end
    end
endmodule

// File: rtl/ddrb4_sram.sv
// Top: burst-of-four double-data-rate SRAM model. One clock at twice the
// K rate; even cycles after reset are K ticks. Wires decode, write and
// read sequencers around the storage array.
module ddrb4_sram #(
    parameter int unsigned ENTRY_AW = 4,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned RD_LAT   = 4,
    localparam int unsigned ADDR_W  = ENTRY_AW + 2,
    localparam int unsigned NBYTE   = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NBYTE-1:0]  wbe,
    output logic              k_tick,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);
    logic                acc_rd;
    logic                acc_wr;
    logic [ENTRY_AW-1:0] acc_entry;
    logic [1:0]          acc_start;
    logic                mem_we;
    logic [ENTRY_AW-1:0] mem_entry;
    logic [1:0]          mem_pos;
    logic [WORD_W-1:0]   mem_data;
    logic [NBYTE-1:0]    mem_be;
    logic [1:0]          wr_ord;
    logic [ENTRY_AW-1:0] f_entry;
    logic [1:0]          f_pos;
    logic [WORD_W-1:0]   f_word;

    ddrb4_cmd_decode #(.ENTRY_AW(ENTRY_AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .k_tick(k_tick), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_entry(acc_entry), .acc_start(acc_start)
    );

    ddrb4_wr_seq #(.ENTRY_AW(ENTRY_AW), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .k_tick(k_tick), .acc_wr(acc_wr),
        .acc_entry(acc_entry), .acc_start(acc_start), .wdata(wdata), .wbe(wbe),
        .mem_we(mem_we), .mem_entry(mem_entry), .mem_pos(mem_pos),
        .mem_data(mem_data), .mem_be(mem_be), .wr_ord(wr_ord)
    );

    ddrb4_store #(.ENTRY_AW(ENTRY_AW), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .w_entry(mem_entry),
        .w_pos(mem_pos), .w_data(mem_data), .w_be(mem_be),
        .r_entry(f_entry), .r_pos(f_pos), .r_word(f_word)
    );

    ddrb4_rd_seq #(.ENTRY_AW(ENTRY_AW), .WORD_W(WORD_W), .RD_LAT(RD_LAT)) u_rd (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_entry(acc_entry),
        .acc_start(acc_start), .f_entry(f_entry), .f_pos(f_pos), .f_word(f_word),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );
endmodule

// File: rtl/ddrb4_sram_chk.sv
// Checker for ddrb4_sram: temporal properties on ports and on the
// hand-offs between decode, write sequencer and output stage.
module ddrb4_sram_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned RD_LAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              k_tick,
    input logic [WORD_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              mem_we,
    input logic [1:0]        wr_ord
);
    logic live;

    // Marks cycles with at least one full cycle out of reset behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R1
    k_alt_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        k_tick != $past(k_tick));

    // R8
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata == '0);

    // R7
    first_word_phase_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        $rose(rdata_oe) |-> (k_tick == ((RD_LAT % 2) == 0)));

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        $rose(rdata_oe) |=> rdata_oe);

    // R4
    cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (acc_rd || acc_wr) |-> !$past(acc_rd || acc_wr, 2));

    // R2
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |-> !(acc_rd || acc_wr));

    // R5
    wr_first_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_ord == 2'd0) |-> k_tick);
endmodule

bind ddrb4_sram ddrb4_sram_chk #(.WORD_W(WORD_W), .RD_LAT(RD_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .k_tick(k_tick), .rdata(rdata),
    .rdata_oe(rdata_oe), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .mem_we(mem_we), .wr_ord(wr_ord)
);

// File: tb/ddrb4_sram_bench.sv
`timescale 1ns/1ps
module ddrb4_sram_bench;
    localparam int EAW = 4;
    localparam int WW  = 16;
    localparam int LAT = 4;
    localparam int NC  = 480;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [EAW+1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [1:0]    wbe = '0;
    logic          k_tick;
    logic [WW-1:0] rdata;
    logic          rdata_oe;

    always #2.5 clk = ~clk;

    ddrb4_sram #(.ENTRY_AW(EAW), .WORD_W(WW), .BYTE_W(8), .RD_LAT(LAT)) u_ddrb4_sram (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .k_tick(k_tick), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Planned stimulus and expectation, per cycle after reset release.
    logic          d_ldn [NC];
    logic          d_rw  [NC];
    logic [EAW+1:0] d_addr [NC];
    logic [WW-1:0] d_wd  [NC];
    logic [1:0]    d_be  [NC];
    logic          x_oe  [NC];
    logic [WW-1:0] x_rd  [NC];
    string         x_tag [NC];
    logic [WW-1:0] mm [16][4];
    int            last_acc = -100;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;
    logic [31:0]   seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:15]);
    endfunction

    // Plan one command at cycle c; the model decides acceptance (R2, R3, R4).
    task automatic plan(input int c, input bit ldn, input bit rdw, input int e,
                        input int s, input logic [63:0] d, input logic [7:0] m,
                        input string tag);
        bit ok;
        d_ldn[c]  = ldn;
        d_rw[c]   = rdw;
        d_addr[c] = {e[EAW-1:0], s[1:0]};
        ok = !ldn && (c % 2 == 0) && (c - last_acc >= 4);
        if (ok) begin
            last_acc = c;
            for (int j = 0; j < 4; j++) begin
                int p;
                p = (s + j) % 4;
                if (!rdw) begin
                    d_wd[c+2+j] = d[j*16 +: 16];
                    d_be[c+2+j] = m[j*2 +: 2];
                    if (m[j*2])   mm[e][p][7:0]  = d[j*16 +: 8];
                    if (m[j*2+1]) mm[e][p][15:8] = d[j*16+8 +: 8];
                end else begin
                    x_oe[c+LAT+j]  = 1'b1;
                    x_rd[c+LAT+j]  = mm[e][p];
                    x_tag[c+LAT+j] = tag;
                end
            end
        end else if (rdw) begin
            for (int j = 0; j < 4; j++)
                if (!x_oe[c+LAT+j]) x_tag[c+LAT+j] = tag;
        end
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            d_ldn[c] = 1'b1; d_rw[c] = c[0]; d_addr[c] = c[5:0];
            d_wd[c] = 16'hDEAD ^ c[15:0]; d_be[c] = 2'b11;
            x_oe[c] = 1'b0; x_rd[c] = '0; x_tag[c] = (c < 2) ? "R1" : "R8";
        end
        for (int e = 0; e < 16; e++)
            for (int p = 0; p < 4; p++) mm[e][p] = '0;

        plan(2,  0, 0, 3, 0, 64'h4444_3333_2222_1111, 8'hFF, "R5");
        plan(6,  0, 1, 3, 0, 64'h0, 8'h0, "R7 R5 aligned read");
        plan(10, 0, 0, 5, 2, 64'h00A3_00A2_00A1_00A0, 8'hFF, "R5");
        plan(14, 0, 1, 5, 1, 64'h0, 8'h0, "R7 wrap read");
        plan(18, 0, 0, 3, 0, 64'h8888_7777_6666_5555, 8'b11_00_10_01, "R6");
        plan(20, 0, 0, 3, 0, 64'h9999_9999_9999_9999, 8'hFF, "R4");
        plan(22, 0, 1, 3, 3, 64'h0, 8'h0, "R9 R6 R4 read after write");
        plan(26, 1, 1, 5, 0, 64'h0, 8'h0, "R2");
        plan(27, 0, 1, 5, 0, 64'h0, 8'h0, "R3");
        plan(30, 0, 1, 5, 0, 64'h0, 8'h0, "R9 read before write");
        plan(34, 0, 0, 5, 3, 64'hBBB3_BBB2_BBB1_BBB0, 8'hFF, "R5");
        plan(38, 0, 1, 5, 0, 64'h0, 8'h0, "R9 read after write");
        plan(42, 0, 1, 9, 1, 64'h0, 8'h0, "R10");

        for (int c = 48; c < NC - 24; c++) begin
            int r;
            r = rnd();
            if (c % 2 == 1) begin
                if (r % 6 == 0) plan(c, 0, r[3], r[6:4], r[8:7], 64'h0, 8'h0, "R3");
            end else begin
                logic [63:0] dd;
                dd = {rnd()[15:0], rnd()[15:0], rnd()[15:0], rnd()[15:0]};
                case (r % 8)
                    0, 1, 2: plan(c, 0, 0, r[6:4], r[8:7], dd, rnd()[7:0], "R6");
                    3, 4, 5: plan(c, 0, 1, r[6:4], r[8:7], 64'h0, 8'h0, "R7 R9");
                    6:       plan(c, 1, r[3], r[6:4], r[8:7], dd, 8'hFF, "R2");
                    default: ;
                endcase
            end
        end

        repeat (3) @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            @(negedge clk);
            rst_n = 1'b1;
            n_cmp++;
            if (rdata_oe !== x_oe[c] || rdata !== x_rd[c] || k_tick !== (c % 2 == 0)) begin
                n_bad++;
                $display("FAIL %s cycle %0d: oe/rdata/k_tick got %b/%h/%b expected %b/%h/%b",
                         x_tag[c], c, rdata_oe, rdata, k_tick, x_oe[c], x_rd[c], (c % 2 == 0));
            end
            ld_n  = d_ldn[c];
            rw    = d_rw[c];
            addr  = d_addr[c];
            wdata = d_wd[c];
            wbe   = d_be[c];
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (NC + 200) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got %0d compared expected %0d", n_cmp, NC);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule